// File: doc/BRIEF.md
# Byte-Quota Round-Robin Scheduler for Four DMA Channels

This block decides which of four DMA channels may drive a single shared data mover. Each channel carries its own 4-bit bandwidth code. The code sets how many bytes the channel may move in one turn. When that limit is reached, the mover passes to the next eligible channel. The mover reports every beat it completes, with a byte count and a flag for the last beat of the transfer. The scheduler adds up those counts against the quota of the channel that holds the grant.

When more than one channel is eligible, a channel that uses up its quota only yields its turn. When it is the only eligible channel, it pauses. It then stays idle until its request line shows a new rising edge. One code value removes the limit completely. A small group of reserved code values falls back to a 1-byte quota and sets a sticky error flag.

Top module: `quota_sched`

## Requirements
- R1: After reset, `grant`, `paused` and `code_err` are all zero.
- R2: A channel is eligible when its `active` bit is set and its `paused` bit is clear. When no grant is held and some channel is eligible, the one-hot `grant` appears on the next clock edge. The channel chosen is the first eligible one in cyclic order after the last granted channel. The search starts at channel 0 after reset, and inactive or paused channels are skipped.
- R3: Channel i's code sits at `bw_code[4i+3:4i]`. A code c from 0 to 10 gives a quota of 2^c bytes. On the edge where the accumulated `beat_bytes` of the turn reach or exceed the quota, the grant is released, so `grant` is zero after that edge. An overshoot also ends the turn.
- R4: Code 15 sets no byte limit. The grant is held for any number of bytes until the transfer completes.
- R5: A beat with `beat_last` set ends the turn on that edge for every code, and the channel is not paused.
- R6: Codes 11 to 14 behave as a 1-byte quota. `code_err` rises on the edge after any active channel holds such a code and stays set until reset.
- R7: If a turn ends on its quota while no other channel is eligible, the channel's `paused` bit is set on that edge and no new grant is issued to it.
- R8: A 0-to-1 change of `req[i]` between two successive clock samples clears `paused[i]` on the second edge. A request held high does not clear it.
- R9: At most one `grant` bit is set, and never for a paused channel. Clearing `active` of the granted channel drops the grant on the next edge. Clearing `active` of a paused channel clears its pause.
- R10: A channel that ends its turn on its quota while another channel is eligible is not paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 4 | Per-channel request line; a rising edge resumes a paused channel |
| active | input | 4 | Per-channel flag showing that a transfer is programmed |
| bw_code | input | 16 | Four 4-bit bandwidth codes, channel 0 in the low nibble |
| beat_valid | input | 1 | The mover completed a beat for the granted channel |
| beat_bytes | input | 4 | Number of bytes moved in that beat |
| beat_last | input | 1 | That beat completes the granted channel's transfer |
| grant | output | 4 | One-hot owner of the data mover, zero when idle |
| paused | output | 4 | Per-channel flag for a channel waiting for a new request edge |
| code_err | output | 1 | Sticky flag for a reserved bandwidth code seen on an active channel |

## Verification
The hardest case to reach is a lone channel that pauses at its quota and then resumes. The request line must rise after the pause edge, and a request that simply stays high must leave the channel paused. The bench therefore drives a single active channel to its quota with two partial beats, so the pause is set without a completing beat. It then checks that no grant follows. After that it raises the request line, sees the pause clear and the grant return, and exhausts the quota again with the request still high to confirm that the level alone does not release it. Overshoot, the unlimited code with more bytes than the largest quota, and reserved codes each get their own scenario.

// File: rtl/quota_sched.sv
module quota_sched #(
  parameter int NCH      = 4,
  parameter int CODE_W   = 4,
  parameter int BEAT_W   = 4,
  parameter int MAX_CODE = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        req,
  input  logic [NCH-1:0]        active,
  input  logic [NCH*CODE_W-1:0] bw_code,
  input  logic                  beat_valid,
  input  logic [BEAT_W-1:0]     beat_bytes,
  input  logic                  beat_last,
  output logic [NCH-1:0]        grant,
  output logic [NCH-1:0]        paused,
  output logic                  code_err
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CNT_W = MAX_CODE + 2;

  logic [NCH-1:0]    grant_q, paused_q, req_q;
  logic [IDX_W-1:0]  last_q, cur_idx, pick_idx;
  logic [CNT_W-1:0]  cnt_q;
  logic              err_q, found, bad_code;
  logic [CODE_W-1:0] cur_code, scan_code;
  logic [CNT_W:0]    quota, sum;

  wire [NCH-1:0] eligible = active & ~paused_q;
  wire           busy     = |grant_q;
  wire           unlim    = &cur_code;
  wire           fin      = beat_valid & beat_last;
  wire           lost     = busy & ~|(grant_q & active);
  wire           hit      = busy & beat_valid & ~unlim & (sum >= quota);
  wire           turn_end = busy & (lost | fin | hit);
  wire           alone    = ~|(eligible & ~grant_q);
  wire [NCH-1:0] rise     = req & ~req_q;
  wire [NCH-1:0] pause_set = (hit & ~fin & ~lost & alone) ? grant_q : '0;

  always_comb begin
    cur_idx = '0;
    for (int i = 0; i < NCH; i++)
      if (grant_q[i]) cur_idx = IDX_W'(i);
  end

  assign cur_code = bw_code[cur_idx*CODE_W +: CODE_W];
  assign quota    = (cur_code <= CODE_W'(MAX_CODE)) ? ((CNT_W+1)'(1) << cur_code) : (CNT_W+1)'(1);
  assign sum      = {1'b0, cnt_q} + (CNT_W+1)'(beat_bytes);

  always_comb begin
    pick_idx = '0;
    found    = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      int j;
      j = (int'(last_q) + k) % NCH;
      if (!found && eligible[j]) begin
        found    = 1'b1;
        pick_idx = IDX_W'(j);
      end
    end
  end

  always_comb begin
    bad_code  = 1'b0;
    scan_code = '0;
    for (int i = 0; i < NCH; i++) begin
      scan_code = bw_code[i*CODE_W +: CODE_W];
      if (active[i] && scan_code > CODE_W'(MAX_CODE) && !(&scan_code))
        bad_code = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q  <= '0;
      paused_q <= '0;
      req_q    <= '0;
      last_q   <= IDX_W'(NCH - 1);
      cnt_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      req_q    <= req;
      err_q    <= err_q | bad_code;
      paused_q <= (paused_q | pause_set) & ~rise & active;
      if (!busy) begin
        if (found) begin
          grant_q  <= NCH'(1) << pick_idx;
          last_q   <= pick_idx;
        end
        cnt_q <= '0;
      end else if (turn_end) begin
        grant_q <= '0;
        cnt_q   <= '0;
      end else if (beat_valid) begin
        cnt_q <= sum[CNT_W-1:0];
      end
    end
  end

  assign grant    = grant_q;
  assign paused   = paused_q;
  assign code_err = err_q;
endmodule

// File: rtl/quota_sched_chk.sv
module quota_sched_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req,
  input logic [NCH-1:0] active,
  input logic           beat_valid,
  input logic           beat_last,
  input logic [NCH-1:0] grant,
  input logic [NCH-1:0] paused,
  input logic           code_err
);
  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));

  // R9
  grant_not_paused_chk: assert property (@(posedge clk) disable iff (!rst_n) (grant & paused) == '0);

  // R5
  last_beat_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant && beat_valid && beat_last) |=> (grant == '0));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) code_err |=> code_err);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R7
    pause_from_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(paused[i]) |-> $past(grant[i]));

    // R8
    resume_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (paused[i] && req[i] && !$past(req[i])) |=> !paused[i]);

    // R2
    grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant[i]) |-> $past(active[i] && !paused[i]));
  end
endmodule

bind quota_sched quota_sched_chk #(.NCH(NCH)) u_quota_sched_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .active(active),
  .beat_valid(beat_valid), .beat_last(beat_last),
  .grant(grant), .paused(paused), .code_err(code_err)
);

// File: tb/test_quota_sched.sv
module test_quota_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0, active = '0;
  logic [15:0] bw_code = '0;
  logic        beat_valid = 1'b0, beat_last = 1'b0;
  logic [3:0]  beat_bytes = '0;
  logic [3:0]  grant, paused;
  logic        code_err;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  quota_sched i_quota_sched (
    .clk(clk), .rst_n(rst_n), .req(req), .active(active), .bw_code(bw_code),
    .beat_valid(beat_valid), .beat_bytes(beat_bytes), .beat_last(beat_last),
    .grant(grant), .paused(paused), .code_err(code_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic beat(input int n, input bit last);
    beat_valid = 1'b1; beat_bytes = 4'(n); beat_last = last;
    cyc();
    beat_valid = 1'b0; beat_last = 1'b0; beat_bytes = '0;
  endtask

  task automatic do_reset();
    active = '0; req = '0; bw_code = '0;
    @(negedge clk); rst_n = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic t_reset();
    do_reset();
    chk(grant == 0, "R1 grant", grant, 0);
    chk(paused == 0, "R1 paused", paused, 0);
    chk(code_err == 0, "R1 code_err", code_err, 0);
  endtask

  task automatic t_lone();
    do_reset();
    bw_code[3:0] = 4'd3; active = 4'b0001;
    cyc();
    chk(grant == 4'b0001, "R2 first grant", grant, 1);
    beat(4, 0);
    chk(grant == 4'b0001, "R3 below quota", grant, 1);
    beat(4, 0);
    chk(grant == 0, "R3 quota reached", grant, 0);
    chk(paused == 4'b0001, "R7 lone pause", paused, 1);
    cyc();
    chk(grant == 0, "R7 no regrant", grant, 0);
    req = 4'b0001;
    cyc();
    chk(paused == 0, "R8 resume on edge", paused, 0);
    cyc();
    chk(grant == 4'b0001, "R8 grant after resume", grant, 1);
    beat(8, 0);
    chk(paused == 4'b0001, "R7 second pause", paused, 1);
    cyc(); cyc();
    chk(paused == 4'b0001, "R8 held level no resume", paused, 1);
    active = 0;
    cyc();
    chk(paused == 0, "R9 inactive clears pause", paused, 0);
    req = 0;
  endtask

  task automatic t_rr();
    do_reset();
    active = 4'b1011;
    cyc();
    chk(grant == 4'b0001, "R2 rr ch0", grant, 1);
    beat(1, 0);
    chk(grant == 0 && paused == 0, "R10 yield no pause", paused, 0);
    cyc();
    chk(grant == 4'b0010, "R2 rr ch1", grant, 2);
    beat(1, 0);
    cyc();
    chk(grant == 4'b1000, "R2 rr skip ch2", grant, 8);
    beat(1, 0);
    cyc();
    chk(grant == 4'b0001, "R2 rr wrap", grant, 1);
    active = 4'b1010;
    cyc();
    chk(grant == 0, "R9 deactivated drops grant", grant, 0);
    active = 0;
  endtask

  task automatic t_overshoot();
    do_reset();
    bw_code = 16'h0002; active = 4'b0011;
    cyc();
    beat(3, 0);
    chk(grant == 4'b0001, "R3 3 of 4 bytes", grant, 1);
    beat(3, 0);
    chk(grant == 0, "R3 overshoot ends turn", grant, 0);
    chk(paused == 0, "R10 no pause with peer", paused, 0);
    cyc();
    chk(grant == 4'b0010, "R2 next channel", grant, 2);
    active = 0;
  endtask

  task automatic t_unlim();
    int held = 1;
    do_reset();
    bw_code[3:0] = 4'hF; active = 4'b0001;
    cyc();
    for (int i = 0; i < 150; i++) begin
      beat(8, 0);
      if (grant != 4'b0001) held = 0;
    end
    chk(held == 1, "R4 unlimited held past 1024 bytes", held, 1);
    beat(8, 1);
    chk(grant == 0, "R5 last beat ends turn", grant, 0);
    chk(paused == 0, "R5 no pause on completion", paused, 0);
    active = 0;
  endtask

  task automatic t_last_short();
    do_reset();
    bw_code[3:0] = 4'd10; active = 4'b0001;
    cyc();
    beat(2, 1);
    chk(grant == 0 && paused == 0, "R5 completion below quota", {paused, grant}, 0);
    active = 0;
  endtask

  task automatic t_reserved();
    do_reset();
    bw_code[3:0] = 4'd12; active = 4'b0001;
    cyc();
    chk(code_err == 1, "R6 reserved flags error", code_err, 1);
    beat(1, 0);
    chk(grant == 0 && paused == 4'b0001, "R6 reserved acts as 1 byte", {paused, grant}, 8'h10);
    active = 0; bw_code = 0;
    cyc(); cyc();
    chk(code_err == 1, "R6 error sticky", code_err, 1);
  endtask

  initial begin
    t_reset();
    t_lone();
    t_rr();
    t_overshoot();
    t_unlim();
    t_last_short();
    t_reserved();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule